// File: doc/BRIEF.md
# Sensor Fault Status Latch

This block drives the single fault status pin of a sensing device. It watches three fault sources: an asynchronous low-supply flag from an analog comparator, a frequency check on the device's internal oscillator, and the parity of a static trim-memory word. If any of them reports a problem, a sticky fault latch sets and stays set after the source recovers. Everything runs on a reference clock, which also serves as the timebase for the oscillator check and for pulse-width measurement.

The only way to clear the latch is a self-test pulse from the board that stays high for a minimum time. Shorter pulses are ignored. A qualified pulse also has no effect while any fault source is still active. The status pin is the latch ORed with the raw self-test input, so a host can pulse self-test and see the status pin follow it. This proves both connections are intact. Reset forces the latch set. A separate valid flag stays low until the first synchronized rising edge of self-test.

Top module: `fault_status_latch`

## Requirements
- R1: `status_out` is high in the same cycle whenever `st_in` is high, whatever the state of the latch.
- R2: A high level on `lv_flag` lasting at least three reference cycles sets the fault latch within four reference cycles.
- R3: The trim word is checked by XOR reduction. A result of 1 (an odd number of set bits) sets the fault latch within three reference cycles. A result of 0 is not a fault.
- R4: The monitor counts rising edges of `mon_clk` over each window of `WIN_CYC` reference cycles. A window with fewer than `MIN_EDGES` edges is a clock fault and sets the latch. Once the windows meet the minimum again, the clock fault clears.
- R5: Once set, the latch stays set after every fault source has gone inactive, until a qualified clear.
- R6: A clear needs `st_in` held high for at least `MIN_HI_CYC`+1 reference cycles. A pulse of `MIN_HI_CYC` cycles or fewer leaves the latch unchanged.
- R7: A qualified self-test pulse does not clear the latch while any fault source is active.
- R8: After reset the latch is set and `status_valid` is low. `status_valid` goes high after the first synchronized rising edge of `st_in` and stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock. It clocks all logic except the monitored-clock toggle. |
| rst_n | input | 1 | Asynchronous active-low reset. |
| mon_clk | input | 1 | Monitored oscillator. Its frequency must be well below half of `ref_clk`. |
| lv_flag | input | 1 | Asynchronous low-supply flag from the comparator. |
| trim_word | input | TRIM_W | Static trim-memory contents. |
| st_in | input | 1 | Self-test pin. It is asynchronous. |
| status_out | output | 1 | Fault latch ORed with `st_in`. |
| status_valid | output | 1 | High once a self-test rising edge has been seen since reset. |

## Verification
Most wrong internal states show up on `status_out` within a few reference cycles. Examples are a latch that fails to hold, a parity flop that misses an odd word, or a width counter that qualifies a pulse too early. Each of these appears once every self-test pulse has ended and the pin is quiet. The pulse-width counter is the most sensitive to off-by-one errors, so the clear decision is exercised just inside and just outside `MIN_HI_CYC`. A wrong decision there appears as a wrong status level about six cycles after the pulse falls. Clock-monitor errors take longest to reach the pins, since at least one full window must pass before they are visible.

// File: rtl/fsl_pkg.sv
package fsl_pkg;

  // Active fault sources, one bit per detector.
  typedef struct packed {
    logic lv;
    logic clk;
    logic par;
  } fsl_fault_t;

  // True when any detector reports a fault.
  function automatic logic fault_any(input fsl_fault_t f);
    return f.lv | f.clk | f.par;
  endfunction

  // A window with fewer edges than the minimum is a clock failure.
  function automatic logic window_short(input int unsigned edges,
                                        input int unsigned min_edges);
    return (edges < min_edges);
  endfunction

  // Has the high-time count reached the qualification limit?
  function automatic logic width_reached(input int unsigned count,
                                         input int unsigned limit);
    return (count >= limit);
  endfunction

endpackage

// File: rtl/fsl_sync.sv
module fsl_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/fsl_parity.sv
module fsl_parity #(
  parameter int unsigned TRIM_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TRIM_W-1:0] trim_word,
  output logic              par_odd
);

  // XOR reduction: 1 means an odd number of set bits.
  function automatic logic odd_of(input logic [TRIM_W-1:0] w);
    return ^w;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) par_odd <= 1'b0;
    else        par_odd <= odd_of(trim_word);
  end

endmodule

// File: rtl/fsl_clk_mon.sv
module fsl_clk_mon #(
  parameter int unsigned WIN_CYC   = 12500,
  parameter int unsigned MIN_EDGES = 25
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic mon_clk,
  output logic clk_fail
);

  localparam int unsigned WW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
  localparam int unsigned EW = $clog2(MIN_EDGES + 1);

  // Toggle in the monitored domain; every flip marks one mon_clk edge.
  logic mon_tog;
  always_ff @(posedge mon_clk or negedge rst_n) begin
    if (!rst_n) mon_tog <= 1'b0;
    else        mon_tog <= ~mon_tog;
  end

  logic tog_s;
  logic tog_d;
  fsl_sync #(.W(1), .STAGES(2)) u_tog_sync (
    .clk   (ref_clk),
    .rst_n (rst_n),
    .d     (mon_tog),
    .q     (tog_s)
  );

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) tog_d <= 1'b0;
    else        tog_d <= tog_s;
  end

  logic mon_edge;
  assign mon_edge = tog_s ^ tog_d;

  logic [WW-1:0] win_cnt;
  logic [EW-1:0] edge_cnt;
  logic          win_end;

  assign win_end = (win_cnt == WW'(WIN_CYC - 1));

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt  <= '0;
      edge_cnt <= '0;
      clk_fail <= 1'b0;
    end else if (win_end) begin
      win_cnt  <= '0;
      edge_cnt <= '0;
      clk_fail <= fsl_pkg::window_short(32'(edge_cnt) + 32'(mon_edge), MIN_EDGES);
    end else begin
      win_cnt <= win_cnt + 1'b1;
      if (mon_edge && (edge_cnt != EW'(MIN_EDGES))) edge_cnt <= edge_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/fsl_st_qual.sv
module fsl_st_qual #(
  parameter int unsigned MIN_HI_CYC = 12500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic st_sync,
  output logic st_rise,
  output logic st_qual
);

  localparam int unsigned CW = $clog2(MIN_HI_CYC + 1);

  logic          st_d;
  logic [CW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_d   <= 1'b0;
      hi_cnt <= '0;
    end else begin
      st_d <= st_sync;
      if (!st_sync)                        hi_cnt <= '0;
      else if (hi_cnt != CW'(MIN_HI_CYC))  hi_cnt <= hi_cnt + 1'b1;
    end
  end

  assign st_rise = st_sync & ~st_d;
  assign st_qual = st_sync & fsl_pkg::width_reached(32'(hi_cnt), MIN_HI_CYC);

endmodule

// File: rtl/fault_status_latch.sv
module fault_status_latch #(
  parameter int unsigned TRIM_W     = 16,
  parameter int unsigned MIN_HI_CYC = 12500,
  parameter int unsigned WIN_CYC    = 12500,
  parameter int unsigned MIN_EDGES  = 25
) (
  input  logic              ref_clk,
  input  logic              rst_n,
  input  logic              mon_clk,
  input  logic              lv_flag,
  input  logic [TRIM_W-1:0] trim_word,
  input  logic              st_in,
  output logic              status_out,
  output logic              status_valid
);

  import fsl_pkg::*;

  // Named internal events, brought out for the checker.
  logic       lv_sync;
  logic       st_sync;
  logic       st_rise;
  logic       st_qual;
  logic       par_odd;
  logic       clk_fail;
  logic       any_fault;
  logic       fault_q;
  logic       valid_q;
  fsl_fault_t faults;

  fsl_sync #(.W(2), .STAGES(2)) u_in_sync (
    .clk   (ref_clk),
    .rst_n (rst_n),
    .d     ({lv_flag, st_in}),
    .q     ({lv_sync, st_sync})
  );

  fsl_st_qual #(.MIN_HI_CYC(MIN_HI_CYC)) u_st_qual (
    .clk     (ref_clk),
    .rst_n   (rst_n),
    .st_sync (st_sync),
    .st_rise (st_rise),
    .st_qual (st_qual)
  );

  fsl_parity #(.TRIM_W(TRIM_W)) u_parity (
    .clk       (ref_clk),
    .rst_n     (rst_n),
    .trim_word (trim_word),
    .par_odd   (par_odd)
  );

  fsl_clk_mon #(.WIN_CYC(WIN_CYC), .MIN_EDGES(MIN_EDGES)) u_clk_mon (
    .ref_clk  (ref_clk),
    .rst_n    (rst_n),
    .mon_clk  (mon_clk),
    .clk_fail (clk_fail)
  );

  assign faults    = '{lv: lv_sync, clk: clk_fail, par: par_odd};
  assign any_fault = fault_any(faults);

  // Sticky latch: set has priority over clear.
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)         fault_q <= 1'b1;
    else if (any_fault) fault_q <= 1'b1;
    else if (st_qual)   fault_q <= 1'b0;
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)       valid_q <= 1'b0;
    else if (st_rise) valid_q <= 1'b1;
  end

  assign status_out   = fault_q | st_in;
  assign status_valid = valid_q;

endmodule

// File: rtl/fsl_checker.sv
module fsl_checker #(
  parameter int unsigned MIN_HI_CYC = 12500
) (
  input logic ref_clk,
  input logic rst_n,
  input logic st_sync,
  input logic st_qual,
  input logic any_fault,
  input logic fault_q,
  input logic valid_q
);

  localparam int unsigned CW = $clog2(MIN_HI_CYC + 1);

  // Independent measure of synchronized self-test high time.
  logic [CW-1:0] hi_seen;
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)                            hi_seen <= '0;
    else if (!st_sync)                     hi_seen <= '0;
    else if (hi_seen != CW'(MIN_HI_CYC))   hi_seen <= hi_seen + 1'b1;
  end

  AST_FAULT_SETS_LATCH: assert property (@(posedge ref_clk) disable iff (!rst_n)
    any_fault |=> fault_q);  // R2

  AST_LATCH_STICKY: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (fault_q && !st_qual) |=> fault_q);  // R5

  AST_CLEAR_BLOCKED: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (fault_q && any_fault && st_qual) |=> fault_q);  // R7

  AST_CLEAR_NEEDS_QUAL: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $fell(fault_q) |-> $past(st_qual));  // R6

  AST_QUAL_WIDTH: assert property (@(posedge ref_clk) disable iff (!rst_n)
    st_qual |-> (hi_seen == CW'(MIN_HI_CYC)));  // R6

  AST_VALID_HOLDS: assert property (@(posedge ref_clk) disable iff (!rst_n)
    valid_q |=> valid_q);  // R8

  AST_VALID_ON_EDGE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(valid_q) |-> $past(st_sync));  // R8

endmodule

bind fault_status_latch fsl_checker #(.MIN_HI_CYC(MIN_HI_CYC)) u_fsl_checker (
  .ref_clk   (ref_clk),
  .rst_n     (rst_n),
  .st_sync   (st_sync),
  .st_qual   (st_qual),
  .any_fault (any_fault),
  .fault_q   (fault_q),
  .valid_q   (valid_q)
);

// File: tb/fault_status_latch_bench.sv
module fault_status_latch_bench;

  localparam int unsigned TRIM_W = 16;
  localparam int unsigned MIN_HI = 200;
  localparam int unsigned WIN    = 200;
  localparam int unsigned MINE   = 20;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              mon_clk = 1'b0;
  logic              lv_flag = 1'b0;
  logic [TRIM_W-1:0] trim_word = 16'h0003;
  logic              st_in = 1'b0;
  logic              status_out;
  logic              status_valid;

  int n_tests = 0;
  int n_fail  = 0;
  int mon_half = 20;
  bit done = 1'b0;

  always #4 clk = ~clk;
  always begin
    #(mon_half);
    mon_clk = ~mon_clk;
  end

  fault_status_latch #(
    .TRIM_W(TRIM_W), .MIN_HI_CYC(MIN_HI), .WIN_CYC(WIN), .MIN_EDGES(MINE)
  ) u_fault_status_latch (
    .ref_clk      (clk),
    .rst_n        (rst_n),
    .mon_clk      (mon_clk),
    .lv_flag      (lv_flag),
    .trim_word    (trim_word),
    .st_in        (st_in),
    .status_out   (status_out),
    .status_valid (status_valid)
  );

  // Bench model: count ones, odd count means fault.
  function automatic logic exp_odd(input logic [TRIM_W-1:0] w);
    int ones = 0;
    for (int i = 0; i < int'(TRIM_W); i++) if (w[i]) ones++;
    return logic'(ones % 2);
  endfunction

  // Bench model: a pulse of len cycles clears only when longer than MIN_HI.
  function automatic logic exp_clears(input int len);
    return (len > int'(MIN_HI));
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_st(input int len);
    st_in = 1'b1;
    tick(len);
    st_in = 1'b0;
    tick(6);
  endtask

  task automatic lv_event();
    lv_flag = 1'b1;
    tick(3);
    lv_flag = 1'b0;
    tick(6);
  endtask

  initial begin
    int unsigned seed_set;
    logic [TRIM_W-1:0] tw;
    seed_set = $urandom(32'd7411);
    tick(5);
    rst_n = 1'b1;
    tick(3);
    check("R8 reset latch", status_out, 1'b1);
    check("R8 reset valid", status_valid, 1'b0);
    tick(WIN + 10);
    check("R8 valid before edge", status_valid, 1'b0);

    // short pulse: valid rises, latch untouched
    pulse_st(MIN_HI - 3);
    check("R8 valid after edge", status_valid, 1'b1);
    check("R6 short pulse no clear", status_out, 1'b1);

    // long pulse clears
    st_in = 1'b1;
    tick(MIN_HI + 3);
    check("R1 status during pulse", status_out, 1'b1);
    st_in = 1'b0;
    tick(6);
    check("R6 long pulse clears", status_out, 1'b0);

    // connectivity: status follows st_in with latch clear
    st_in = 1'b1;
    #1 check("R1 status follows st high", status_out, 1'b1);
    tick(2);
    st_in = 1'b0;
    #1 check("R1 status follows st low", status_out, 1'b0);
    tick(4);

    // low supply sets, stays
    lv_event();
    check("R2 low supply sets latch", status_out, 1'b1);
    tick(20);
    check("R5 latch sticky", status_out, 1'b1);

    // clear blocked while low supply active
    lv_flag = 1'b1;
    tick(4);
    pulse_st(MIN_HI + 10);
    check("R7 clear blocked by active fault", status_out, 1'b1);
    lv_flag = 1'b0;
    tick(4);
    check("R5 sticky after source gone", status_out, 1'b1);
    pulse_st(MIN_HI + 3);
    check("R6 clear after fault gone", status_out, 1'b0);

    // parity: directed then random words
    for (int k = 0; k < 12; k++) begin
      logic odd;
      if (k == 0)      tw = 16'h0001;
      else if (k == 1) tw = 16'h8001;
      else             tw = TRIM_W'($urandom);
      trim_word = tw;
      odd = exp_odd(tw);
      tick(4);
      check("R3 trim parity", status_out, odd);
      if (odd) begin
        trim_word = tw ^ 16'h0004;
        tick(3);
        pulse_st(MIN_HI + 3);
        check("R3 even trim allows clear", status_out, 1'b0);
      end
    end

    // clock monitor: slow oscillator
    mon_half = 80;
    tick(3 * WIN);
    check("R4 slow clock sets latch", status_out, 1'b1);
    pulse_st(MIN_HI + 5);
    check("R7 clear blocked by slow clock", status_out, 1'b1);
    mon_half = 20;
    tick(2 * WIN + 20);
    pulse_st(MIN_HI + 3);
    check("R4 clock recovered, clear", status_out, 1'b0);

    // random pulse widths around the limit
    for (int k = 0; k < 10; k++) begin
      int w;
      lv_event();
      w = int'(MIN_HI) - 40 + int'($urandom_range(0, 80));
      if (w == int'(MIN_HI) || w == int'(MIN_HI) + 1) w = int'(MIN_HI) + 2;
      pulse_st(w);
      check("R6 random width", status_out, !exp_clears(w));
      if (exp_clears(w) == 1'b0) pulse_st(MIN_HI + 3);
    end

    check("R8 valid stays high", status_valid, 1'b1);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule